// File: doc/BRIEF.md
# Pin Bank Output Data and Drive-Enable Registers

This block holds the two control words of a bank of general-purpose pins: the value driven onto each pin and the enable that decides whether the pin is driven at all. Each word can be changed in two ways. A full-word write replaces every bit. Two half-word masked writes update only selected bits. A masked write word carries a per-bit mask in its upper half and new bit values in its lower half. Software can therefore change one pin's value or direction in a single write, without a read-modify-write sequence that could overwrite another agent's update.

A simple register port drives the block: one write strobe with address and data, and a separate read address with combinational read data. The two registered words drive the pad value and pad enable outputs directly. The address map is fixed. Address bit 2 selects the word: 0 for pin values, 1 for drive enables. The low two address bits select the access: 0 is a full-word write, 1 is a masked write of the lower half, 2 is a masked write of the upper half, and 3 is unmapped.

Top module: `pad_drive_regs`

## Requirements
- R1: While reset is asserted, and after it is released, pad values and pad drive enables are all zero until a write changes them.
- R2: A write to address 0 sets all 32 pad value bits to the written word. The new value appears on the output after the clock edge that samples the write.
- R3: A write to address 1 treats bits 31:16 as a mask and bits 15:0 as data. For each i in 0..15, pad value bit i takes data bit i when mask bit i is 1 and otherwise keeps its value. Bits 31:16 of the pad value do not change.
- R4: A write to address 2 updates pad value bit 16+j from data bit j when mask bit 16+j of the written word is 1, for j in 0..15. Pad value bits 15:0 do not change.
- R5: The drive-enable word follows the same scheme at addresses 4 (full word), 5 (masked lower half) and 6 (masked upper half). A 1 in bit i enables drive on pin i.
- R6: Reading address 0 or 4 returns the current full 32-bit word, including changes made through masked writes.
- R7: Reading a masked address (1, 2, 5 or 6) returns zero in bits 31:16 and the corresponding current 16-bit half of the word in bits 15:0.
- R8: A write to address 3 or 7 changes neither word. Reading those addresses returns zero.
- R9: Without a write strobe both words hold their values. A masked write whose mask is all zero leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Combinational read data for rd_addr_i |
| pad_out_o | output | 32 | Value driven to each pin |
| pad_oe_o | output | 32 | Drive enable for each pin |

## Verification
Each write is sampled on a rising edge, and its effect is due on pad_out_o and pad_oe_o right after that same edge, one cycle after the strobe is presented. Read data is combinational from the read address and the registered words. A readback therefore reflects a write from the cycle that follows it. The bench drives inputs on falling edges and checks the pad outputs at the next falling edge after the sampling edge. It applies each read address in the low phase and samples read data shortly after, so every check lands where exactly one register stage has been crossed.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

  localparam int unsigned ADDR_W = 3;

  // Bit 2 selects the word, bits 1:0 select the access kind.
  typedef enum logic [ADDR_W-1:0] {
    A_VAL_FULL = 3'd0,
    A_VAL_LO   = 3'd1,
    A_VAL_HI   = 3'd2,
    A_VAL_NONE = 3'd3,
    A_EN_FULL  = 3'd4,
    A_EN_LO    = 3'd5,
    A_EN_HI    = 3'd6,
    A_EN_NONE  = 3'd7
  } reg_addr_e;

  localparam logic [1:0] K_FULL = 2'd0;
  localparam logic [1:0] K_LO   = 2'd1;
  localparam logic [1:0] K_HI   = 2'd2;

  typedef struct packed {
    logic full;
    logic lo;
    logic hi;
  } wr_sel_t;

endpackage

// File: rtl/pdr_decode.sv
module pdr_decode
  import pdr_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output wr_sel_t           val_sel_o,
  output wr_sel_t           en_sel_o
);

  wr_sel_t kind_sel;

  always_comb begin
    kind_sel = '0;
    if (wr_en_i) begin
      unique case (wr_addr_i[1:0])
        K_FULL:  kind_sel.full = 1'b1;
        K_LO:    kind_sel.lo   = 1'b1;
        K_HI:    kind_sel.hi   = 1'b1;
        default: kind_sel      = '0;
      endcase
    end
  end

  assign val_sel_o = wr_addr_i[2] ? '0 : kind_sel;
  assign en_sel_o  = wr_addr_i[2] ? kind_sel : '0;

endmodule

// File: rtl/pdr_word_reg.sv
module pdr_word_reg
  import pdr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  wr_sel_t      sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  localparam int unsigned HALF = W / 2;

  logic [W-1:0]    q_r;
  logic [W-1:0]    q_nxt;
  logic            upd;
  logic [HALF-1:0] mask;
  logic [HALF-1:0] data;

  assign mask = wdata_i[W-1:HALF];
  assign data = wdata_i[HALF-1:0];
  assign upd  = sel_i.full | sel_i.lo | sel_i.hi;

  // Per-half next state; a masked strobe wins over a full-word strobe.
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic            half_we;
    logic [HALF-1:0] cur;
    assign half_we = (h == 0) ? sel_i.lo : sel_i.hi;
    assign cur     = q_r[h*HALF +: HALF];
    always_comb begin
      if (half_we) begin
        q_nxt[h*HALF +: HALF] = (cur & ~mask) | (data & mask);
      end else if (sel_i.full) begin
        q_nxt[h*HALF +: HALF] = wdata_i[h*HALF +: HALF];
      end else begin
        q_nxt[h*HALF +: HALF] = cur;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r <= '0;
    end else if (upd) begin
      q_r <= q_nxt;
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/pdr_readback.sv
module pdr_readback
  import pdr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [W-1:0]      val_i,
  input  logic [W-1:0]      en_i,
  output logic [W-1:0]      rd_data_o
);

  localparam int unsigned HALF = W / 2;

  logic [W-1:0] word;

  assign word = rd_addr_i[2] ? en_i : val_i;

  always_comb begin
    unique case (rd_addr_i[1:0])
      K_FULL:  rd_data_o = word;
      K_LO:    rd_data_o = {{HALF{1'b0}}, word[HALF-1:0]};
      K_HI:    rd_data_o = {{HALF{1'b0}}, word[W-1:HALF]};
      default: rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/pad_drive_regs.sv
module pad_drive_regs
  import pdr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [W-1:0]      rd_data_o,
  output logic [W-1:0]      pad_out_o,
  output logic [W-1:0]      pad_oe_o
);

  wr_sel_t val_sel;
  wr_sel_t en_sel;

  pdr_decode u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .val_sel_o (val_sel),
    .en_sel_o  (en_sel)
  );

  pdr_word_reg #(.W(W)) u_val (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (val_sel),
    .wdata_i (wr_data_i),
    .q_o     (pad_out_o)
  );

  pdr_word_reg #(.W(W)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (en_sel),
    .wdata_i (wr_data_i),
    .q_o     (pad_oe_o)
  );

  pdr_readback #(.W(W)) u_rd (
    .rd_addr_i (rd_addr_i),
    .val_i     (pad_out_o),
    .en_i      (pad_oe_o),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/pdr_checker.sv
module pdr_checker
  import pdr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [W-1:0]      wr_data_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [W-1:0]      rd_data_o,
  input logic [W-1:0]      pad_out_o,
  input logic [W-1:0]      pad_oe_o
);

  localparam int unsigned HALF = W / 2;

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (pad_out_o == '0 && pad_oe_o == '0));

  assert_full_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_VAL_FULL) |=> pad_out_o == $past(wr_data_i));

  assert_masked_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_VAL_LO) |=>
      (pad_out_o[HALF-1:0] ==
         (($past(pad_out_o[HALF-1:0]) & ~$past(wr_data_i[W-1:HALF])) |
          ($past(wr_data_i[HALF-1:0]) & $past(wr_data_i[W-1:HALF]))))
      && $stable(pad_out_o[W-1:HALF]));

  assert_masked_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_VAL_HI) |=>
      (pad_out_o[W-1:HALF] ==
         (($past(pad_out_o[W-1:HALF]) & ~$past(wr_data_i[W-1:HALF])) |
          ($past(wr_data_i[HALF-1:0]) & $past(wr_data_i[W-1:HALF]))))
      && $stable(pad_out_o[HALF-1:0]));

  assert_en_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_EN_FULL) |=> pad_oe_o == $past(wr_data_i));

  assert_read_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == A_VAL_FULL) |-> rd_data_o == pad_out_o);

  assert_read_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == A_EN_HI) |-> rd_data_o == {{HALF{1'b0}}, pad_oe_o[W-1:HALF]});

  assert_unmapped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i[1:0] == 2'd3) |=> ($stable(pad_out_o) && $stable(pad_oe_o)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(pad_out_o) && $stable(pad_oe_o)));

endmodule

bind pad_drive_regs pdr_checker #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o)
);

// File: tb/pad_drive_regs_test.sv
`timescale 1ns/1ps
module pad_drive_regs_test;

  localparam int NV = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [2:0]  wr_addr_i;
  logic [31:0] wr_data_i;
  logic [2:0]  rd_addr_i;
  logic [31:0] rd_data_o;
  logic [31:0] pad_out_o;
  logic [31:0] pad_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pad_drive_regs uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o)
  );

  // Stimulus vectors with expected words after each write.
  localparam logic [2:0] V_ADDR [NV] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5,
                                         3'd6, 3'd3, 3'd1, 3'd2, 3'd7};
  localparam logic [31:0] V_DATA [NV] = '{
    32'hA5A5_5A5A, 32'hFF00_1234, 32'h000F_FFFF, 32'h0000_FFFF, 32'h0F0F_0000,
    32'hFFFF_8001, 32'hDEAD_BEEF, 32'h0000_FFFF, 32'hFFFF_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] V_OUT [NV] = '{
    32'hA5A5_5A5A, 32'hA5A5_125A, 32'hA5AF_125A, 32'hA5AF_125A, 32'hA5AF_125A,
    32'hA5AF_125A, 32'hA5AF_125A, 32'hA5AF_125A, 32'h0000_125A, 32'h0000_125A};
  localparam logic [31:0] V_OE [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h0000_FFFF, 32'h0000_F0F0,
    32'h8001_F0F0, 32'h8001_F0F0, 32'h8001_F0F0, 32'h8001_F0F0, 32'h8001_F0F0};

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd7: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    rd_addr_i = a;
    #0.5;
    chk(tag, rd_data_o, exp);
  endtask

  task automatic read_all(input logic [31:0] ev, input logic [31:0] ee);
    read_chk("R6 value full", 3'd0, ev);
    read_chk("R7 value lo",   3'd1, {16'h0, ev[15:0]});
    read_chk("R7 value hi",   3'd2, {16'h0, ev[31:16]});
    read_chk("R8 value none", 3'd3, 32'h0);
    read_chk("R6 enable full",3'd4, ee);
    read_chk("R7 enable lo",  3'd5, {16'h0, ee[15:0]});
    read_chk("R7 enable hi",  3'd6, {16'h0, ee[31:16]});
    read_chk("R8 enable none",3'd7, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #40000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
    repeat (3) @(negedge clk_i);
    // R1: outputs are zero during reset
    chk("R1 value in reset", pad_out_o, 32'h0);
    chk("R1 enable in reset", pad_oe_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 value after reset", pad_out_o, 32'h0);
    chk("R1 enable after reset", pad_oe_o, 32'h0);
    read_all(32'h0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_write(V_ADDR[i], V_DATA[i]);
      chk(tag_of(V_ADDR[i]), pad_out_o, V_OUT[i]);
      chk(tag_of(V_ADDR[i]), pad_oe_o, V_OE[i]);
      read_all(V_OUT[i], V_OE[i]);
    end

    // R9: idle cycles hold both words
    repeat (4) @(negedge clk_i);
    chk("R9 idle value", pad_out_o, 32'h0000_125A);
    chk("R9 idle enable", pad_oe_o, 32'h8001_F0F0);

    // R9: zero mask on enable upper half is a no-op
    do_write(3'd6, 32'h0000_7FFE);
    chk("R9 zero mask enable", pad_oe_o, 32'h8001_F0F0);

    // R3/R5: back-to-back writes on consecutive edges
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'd1; wr_data_i = 32'h0001_0001;
    @(negedge clk_i);
    chk("R3 back-to-back first", pad_out_o, 32'h0000_125B);
    wr_addr_i = 3'd5; wr_data_i = 32'h8000_8000;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R5 back-to-back second", pad_oe_o, 32'h8001_F0F0 | 32'h0000_8000);
    chk("R3 back-to-back value kept", pad_out_o, 32'h0000_125B);

    // R1: reset mid-run clears both words
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset value", pad_out_o, 32'h0);
    chk("R1 async reset enable", pad_oe_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    read_all(32'h0, 32'h0);

    finish_run();
  end

endmodule